// File: doc/BRIEF.md
# Privilege Mode and Preemption Timer

This block keeps track of whether the processor runs in kernel or user mode and owns a countdown timer that lets the kernel take back control from a running user program. It watches four request lines from the pipeline: system call, privileged operation attempt, timer load and return-to-user. From these it decides, every clock, whether execution must be redirected into the kernel. It also reports why kernel entry happened.

Every entry into kernel mode from user mode produces a one-cycle redirect pulse carrying one fixed vector address. The only way back to user mode is an explicit return issued while in kernel mode. The timer can be loaded only from kernel mode. A load attempt, a privileged operation or a return request made in user mode is not carried out. Instead it becomes a trap with a violation cause. The timer counts down once per clock, stops at zero and signals expiry exactly once per load.

Top module: `priv_guard`

## Requirements
- R1: After reset `mode_o` is 0 (kernel; 1 means user), `redirect_vld` and `tmr_irq` are 0, `redirect_pc` is 0 and `cause_o` is 2'b00.
- R2: A clock edge that moves the block from user to kernel mode also raises `redirect_vld` for exactly one cycle, with `redirect_pc` equal to `VEC_ADDR`. `redirect_vld` never rises on any other edge, and `redirect_pc` is 0 while `redirect_vld` is low.
- R3: A load in kernel mode with value N>0 and `tmr_load_en`=1 makes `tmr_irq` high for the one cycle that follows the N-th clock edge after the load edge.
- R4: After expiry the timer stays at zero and raises no further `tmr_irq` until it is reloaded. A load with `tmr_load_en`=0 never raises `tmr_irq`.
- R5: Timer expiry while in user mode enters kernel mode, with `cause_o`=2'b01 (timer).
- R6: In user mode, `tmr_load_req`, `priv_op_req` and `ret_req` are not carried out: the timer is left unchanged and the block traps to kernel mode with `cause_o`=2'b11 (violation).
- R7: `syscall_req` in user mode traps with `cause_o`=2'b10. In kernel mode `syscall_req` has no effect.
- R8: When several causes arrive on the same edge in user mode, the timer wins over a violation, and a violation wins over a system call.
- R9: Only `ret_req` in kernel mode switches to user mode, and it raises no redirect. A return made on the same edge as a timer expiry is refused, and the block stays in kernel mode.
- R10: Timer expiry in kernel mode pulses `tmr_irq` but leaves the mode and `cause_o` unchanged and raises no redirect.
- R11: A kernel-mode load on the edge where the timer would expire takes precedence: no `tmr_irq` is raised for the old count, and the new count starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| syscall_req | input | 1 | System call request |
| priv_op_req | input | 1 | Attempt to perform a privileged operation |
| tmr_load_req | input | 1 | Timer load request |
| tmr_load_val | input | TMR_W | Count to load |
| tmr_load_en | input | 1 | Timer enable written with the load |
| ret_req | input | 1 | Return-to-user request |
| mode_o | output | 1 | Current mode, 0 kernel, 1 user |
| redirect_vld | output | 1 | One-cycle kernel entry redirect |
| redirect_pc | output | PC_W | Redirect target, the kernel vector |
| tmr_irq | output | 1 | One-cycle timer expiry pulse |
| cause_o | output | 2 | Reason for the most recent kernel entry |

## Verification
A wrong mode bit shows on `mode_o` at once. It also shows on the next request, because a trap that should redirect stays silent, or a silent request redirects, one cycle after the edge. A wrong timer count appears only as `tmr_irq` arriving early, late or twice, so the bench counts edges from each load to the expected pulse. It also watches a stretch of quiet cycles after expiry. A wrong priority or cause is exposed on `cause_o` in the cycle after the edge on which several requests collide.

// File: rtl/pg_pkg.sv
// Package: shared mode and cause encodings for the privilege guard.
// Assumes: kernel is encoded as 0 so that reset clears to the safe mode.
package pg_pkg;
    typedef enum logic {
        MODE_KERNEL = 1'b0,
        MODE_USER   = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_TIMER   = 2'b01,
        CAUSE_SYSCALL = 2'b10,
        CAUSE_VIOL    = 2'b11
    } cause_e;
endpackage

// File: rtl/pg_timer.sv
// Module: preemption countdown. Loads a count and an enable, decrements
// once per clock while enabled and non-zero, and stops at zero.
// Assumes: load_ok is already qualified by kernel mode. A load wins over
// an expiry on the same edge.
module pg_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ok,
    input  logic [TMR_W-1:0] load_val,
    input  logic             load_en,
    output logic             fire,
    output logic             irq
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt_q;
    logic             en_q;

    // Expiry: the last decrement of an enabled count, unless a load replaces it.
    assign fire = en_q && (cnt_q == ONE) && !load_ok;

    // Count register: reload, or step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (load_ok) begin
            cnt_q <= load_val;
            en_q  <= load_en;
        end else if (en_q && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Interrupt pulse: one cycle per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end
endmodule

// File: rtl/pg_arbiter.sv
// Module: picks whether a kernel entry happens on this edge and its cause.
// Assumes: requests only trap from user mode. Order is timer, violation,
// then system call.
module pg_arbiter
    import pg_pkg::*;
(
    input  logic   in_user,
    input  logic   fire,
    input  logic   syscall_req,
    input  logic   priv_op_req,
    input  logic   load_req,
    input  logic   ret_req,
    output logic   enter,
    output cause_e cause
);
    logic viol;

    // Any privileged action attempted from user mode counts as a violation.
    assign viol = priv_op_req || load_req || ret_req;

    // Fixed-priority selection of the entry cause.
    always_comb begin
        enter = 1'b0;
        cause = CAUSE_NONE;
        if (in_user) begin
            if (fire) begin
                enter = 1'b1;
                cause = CAUSE_TIMER;
            end else if (viol) begin
                enter = 1'b1;
                cause = CAUSE_VIOL;
            end else if (syscall_req) begin
                enter = 1'b1;
                cause = CAUSE_SYSCALL;
            end
        end
    end
endmodule

// File: rtl/pg_mode.sv
// Module: mode register, cause register and redirect pulse.
// Assumes: enter is only raised in user mode. A return is refused on an
// edge where the timer expires.
module pg_mode
    import pg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enter,
    input  cause_e cause_in,
    input  logic   ret_req,
    input  logic   fire,
    output mode_e  mode,
    output cause_e cause,
    output logic   redir
);
    // Mode: enter kernel on a trap, leave only by an accepted return.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        mode <= MODE_KERNEL;
        else if (enter)                                    mode <= MODE_KERNEL;
        else if (mode == MODE_KERNEL && ret_req && !fire) mode <= MODE_USER;
    end

    // Cause: latched on each kernel entry and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)     cause <= CAUSE_NONE;
        else if (enter) cause <= cause_in;
    end

    // Redirect: one cycle per kernel entry.
    always_ff @(posedge clk) begin
        if (!rst_n) redir <= 1'b0;
        else        redir <= enter;
    end
endmodule

// File: rtl/priv_guard.sv
// Module: top of the privilege guard. Joins the timer, the arbiter and the
// mode register, and drives the fixed kernel vector on each redirect.
// Assumes: request inputs are single-cycle, synchronous to clk.
module priv_guard
    import pg_pkg::*;
#(
    parameter int              TMR_W    = 16,
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_ADDR = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             syscall_req,
    input  logic             priv_op_req,
    input  logic             tmr_load_req,
    input  logic [TMR_W-1:0] tmr_load_val,
    input  logic             tmr_load_en,
    input  logic             ret_req,
    output logic             mode_o,
    output logic             redirect_vld,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             tmr_irq,
    output logic [1:0]       cause_o
);
    mode_e  mode;
    cause_e cause_sel;
    cause_e cause_q;
    logic   fire;
    logic   enter;
    logic   load_ok;
    logic   in_user;

    assign in_user = (mode == MODE_USER);
    assign load_ok = !in_user && tmr_load_req;

    pg_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ok  (load_ok),
        .load_val (tmr_load_val),
        .load_en  (tmr_load_en),
        .fire     (fire),
        .irq      (tmr_irq)
    );

    pg_arbiter u_arb (
        .in_user     (in_user),
        .fire        (fire),
        .syscall_req (syscall_req),
        .priv_op_req (priv_op_req),
        .load_req    (tmr_load_req),
        .ret_req     (ret_req),
        .enter       (enter),
        .cause       (cause_sel)
    );

    pg_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (enter),
        .cause_in (cause_sel),
        .ret_req  (ret_req),
        .fire     (fire),
        .mode     (mode),
        .cause    (cause_q),
        .redir    (redirect_vld)
    );

    assign mode_o      = mode;
    assign cause_o     = cause_q;
    assign redirect_pc = redirect_vld ? VEC_ADDR : '0;
endmodule

// File: rtl/pg_checker.sv
// Module: port-level properties of the privilege guard, bound to the top.
module pg_checker #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_ADDR = 32'h0000_0100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_req,
    input logic            mode_o,
    input logic            redirect_vld,
    input logic [PC_W-1:0] redirect_pc,
    input logic            tmr_irq,
    input logic [1:0]      cause_o
);
    p_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> redirect_pc == VEC_ADDR);

    p_user_exit_redirects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> (redirect_vld == !mode_o));

    p_kernel_no_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |=> !redirect_vld);

    p_redirect_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> cause_o != 2'b00);

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |=> !tmr_irq);

    p_timer_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> (!tmr_irq || cause_o == 2'b01));

    p_kernel_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && !ret_req) |=> !mode_o);
endmodule

bind priv_guard pg_checker #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_req      (ret_req),
    .mode_o       (mode_o),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .tmr_irq      (tmr_irq),
    .cause_o      (cause_o)
);

// File: tb/sim_priv_guard.sv
module sim_priv_guard;
    localparam int          CLK_PERIOD = 10;
    localparam int          TW  = 16;
    localparam int          PW  = 32;
    localparam logic [31:0] VEC = 32'h0000_0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sc = 1'b0, po = 1'b0, ld = 1'b0, le = 1'b0, rt = 1'b0;
    logic [TW-1:0] lv = '0;
    logic          mode_o, redirect_vld, tmr_irq;
    logic [PW-1:0] redirect_pc;
    logic [1:0]    cause_o;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic       m;
        logic       r;
        logic       i;
        logic [1:0] c;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_guard #(.TMR_W(TW), .PC_W(PW), .VEC_ADDR(VEC)) u0 (
        .clk(clk), .rst_n(rst_n), .syscall_req(sc), .priv_op_req(po),
        .tmr_load_req(ld), .tmr_load_val(lv), .tmr_load_en(le), .ret_req(rt),
        .mode_o(mode_o), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
        .tmr_irq(tmr_irq), .cause_o(cause_o)
    );

    // Compare one expected item against the ports.
    task automatic compare(input exp_t e);
        logic [PW-1:0] epc;
        epc = e.r ? VEC : '0;
        total++;
        if (mode_o !== e.m || redirect_vld !== e.r || redirect_pc !== epc ||
            tmr_irq !== e.i || cause_o !== e.c) begin
            fails++;
            $display("FAIL %s: got mode=%0b red=%0b pc=%h irq=%0b cause=%0b, exp mode=%0b red=%0b pc=%h irq=%0b cause=%0b",
                     e.tag, mode_o, redirect_vld, redirect_pc, tmr_irq, cause_o,
                     e.m, e.r, epc, e.i, e.c);
        end
    endtask

    // Monitor: pops one expectation per cycle, away from the active edge.
    always @(negedge clk) begin
        if (sb.size() > 0) compare(sb.pop_front());
    end

    // Driver: apply one cycle of requests, then queue the expected result.
    task automatic cyc(input logic s, p, l, input logic [TW-1:0] v, input logic e, r,
                       input logic em, er, ei, input logic [1:0] ec, input string tag);
        exp_t x;
        sc = s; po = p; ld = l; lv = v; le = e; rt = r;
        @(posedge clk);
        x.m = em; x.r = er; x.i = ei; x.c = ec; x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        sc = 0; po = 0; ld = 0; lv = '0; le = 0; rt = 0;
    endtask

    task automatic idle(input int n, input logic em, input logic [1:0] ec, input string tag);
        for (int k = 0; k < n; k++) cyc(0,0,0,'0,0,0, em,0,0, ec, tag);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        begin
            exp_t x0;
            x0.m = 0; x0.r = 0; x0.i = 0; x0.c = 2'b00; x0.tag = "R1 reset";
            compare(x0);
        end
        rst_n = 1'b1;
        // R9 return from kernel, no redirect
        cyc(0,0,0,'0,0,1, 1,0,0,2'b00, "R9 return");
        // R7 R2 syscall from user
        cyc(1,0,0,'0,0,0, 0,1,0,2'b10, "R7 syscall trap");
        idle(1, 0, 2'b10, "R2 redirect one cycle");
        cyc(1,0,0,'0,0,0, 0,0,0,2'b10, "R7 syscall in kernel ignored");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b10, "R9 return");
        // R6 privileged op from user
        cyc(0,1,0,'0,0,0, 0,1,0,2'b11, "R6 priv op trap");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b11, "R9 return");
        // R6 timer load from user is not carried out
        cyc(0,0,1,16'd2,1,0, 0,1,0,2'b11, "R6 user load trap");
        idle(5, 0, 2'b11, "R6 user load left timer idle");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b11, "R9 return");
        cyc(0,0,0,'0,0,1, 0,1,0,2'b11, "R6 return in user traps");
        // R3 R5 count of 3 expires in user mode
        cyc(0,0,1,16'd3,1,0, 0,0,0,2'b11, "R3 kernel load");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b11, "R9 return");
        idle(1, 1, 2'b11, "R3 counting");
        cyc(0,0,0,'0,0,0, 0,1,1,2'b01, "R5 R3 expiry trap");
        idle(1, 0, 2'b01, "R4 irq single");
        idle(6, 0, 2'b01, "R4 stays at zero");
        // R8 timer beats violation and syscall
        cyc(0,0,1,16'd2,1,0, 0,0,0,2'b01, "R3 kernel load");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b01, "R9 return");
        cyc(1,1,0,'0,0,0, 0,1,1,2'b01, "R8 timer wins");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b01, "R9 return");
        cyc(1,1,0,'0,0,0, 0,1,0,2'b11, "R8 violation over syscall");
        // R10 expiry in kernel mode
        cyc(0,0,1,16'd2,1,0, 0,0,0,2'b11, "R3 kernel load");
        idle(1, 0, 2'b11, "R10 counting");
        cyc(0,0,0,'0,0,0, 0,0,1,2'b11, "R10 kernel expiry");
        idle(1, 0, 2'b11, "R10 after expiry");
        // R9 return refused on expiry edge
        cyc(0,0,1,16'd2,1,0, 0,0,0,2'b11, "R3 kernel load");
        idle(1, 0, 2'b11, "R9 counting");
        cyc(0,0,0,'0,0,1, 0,0,1,2'b11, "R9 return refused at expiry");
        cyc(0,0,0,'0,0,1, 1,0,0,2'b11, "R9 return");
        // R11 reload on the expiry edge
        cyc(1,0,0,'0,0,0, 0,1,0,2'b10, "R7 syscall trap");
        cyc(0,0,1,16'd2,1,0, 0,0,0,2'b10, "R11 first load");
        idle(1, 0, 2'b10, "R11 counting");
        cyc(0,0,1,16'd3,1,0, 0,0,0,2'b10, "R11 reload wins");
        idle(2, 0, 2'b10, "R11 new count");
        cyc(0,0,0,'0,0,0, 0,0,1,2'b10, "R11 new expiry");
        // R4 load with enable low
        cyc(0,0,1,16'd2,0,0, 0,0,0,2'b10, "R4 disabled load");
        idle(4, 0, 2'b10, "R4 disabled never fires");
        @(posedge clk);
        @(posedge clk);
        summary();
    end
endmodule